// File: doc/BRIEF.md
# Masked Vector Double-to-Int64 Truncating Converter

This block takes a vector of IEEE-754 double-precision values, up to eight 64-bit lanes, and converts each one to a signed 64-bit integer. Every conversion rounds toward zero. The caller picks how many lanes take part: 2, 4 or 8 lanes, for a 128-, 256- or 512-bit vector. A per-lane write mask chooses which lanes receive a new result. Each lane that is masked off either keeps the matching lane of a supplied old destination value or is cleared to zero. A broadcast option feeds lane 0 of the source to every lane.

Each result carries two flags. The invalid flag is the OR across all lanes that were written, and so is the inexact flag. A value that has no signed 64-bit form becomes the fixed indefinite pattern. NaN, infinity and out-of-range values all fall in this group.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them.
- An operand set is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result stays exactly as it is and no new operand set is taken.

Top module: `f64_to_i64_vec`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. An operand set accepted on one rising edge appears on `out_valid`/`out_data` after that same edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output stays unchanged. Every accepted operand set produces exactly one result, in order.
- R2: Lane j of source and result occupies bits [64j+63:64j]. Each written lane gets the source value truncated toward zero as a two's-complement 64-bit integer.
- R3: `in_vlen` sets the number of active lanes: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 gives 8 lanes. Every result bit above the active lanes is zero.
- R4: When `in_mask_en` is 0, every active lane is written. When it is 1, active lane j is written only if `in_mask[j]` is 1.
- R5: An active lane that is not written takes the matching lane of `in_old` when `in_zero_mode` is 0, and takes zero when `in_zero_mode` is 1.
- R6: When `in_bcast` is 1, every written lane converts source bits [63:0] and ignores its own source lane.
- R7: A lane whose input has no signed 64-bit form gives 0x8000000000000000 and sets `out_invalid`. This covers NaN, either infinity, any value at or above 2^63, and any value below -2^63. Exactly -2^63 converts to 0x8000000000000000 without setting the invalid flag.
- R8: `out_inexact` is set when a written lane drops nonzero fraction bits. Denormals convert to 0 and set it. Zeros of either sign and integral values convert without setting it.
- R9: Lanes that are inactive or masked off never set `out_invalid` or `out_inexact`, whatever they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set valid |
| in_ready | output | 1 | Block can accept an operand set |
| in_vlen | input | 2 | Vector length select (0: 128, 1: 256, 2/3: 512 bits) |
| in_mask_en | input | 1 | Enable the per-lane write mask |
| in_mask | input | 8 | Per-lane write mask, bit j for lane j |
| in_zero_mode | input | 1 | 1 clears unwritten lanes, 0 keeps the old value in them |
| in_bcast | input | 1 | Convert source lane 0 in every lane |
| in_src | input | 512 | Source doubles |
| in_old | input | 512 | Old destination value used by merging |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 512 | Converted integer vector |
| out_invalid | output | 1 | OR of invalid conditions over written lanes |
| out_inexact | output | 1 | OR of inexact conditions over written lanes |

## Verification
The conversion is driven with several kinds of input:
- Values with a fraction of each sign show truncation apart from rounding to nearest.
- Exact integers up to 2^52 and the largest double below 2^63 test the left-shift path without false inexact flags.
- NaN, both infinities, 2^63 and exactly -2^63 separate the invalid boundary from the one legal extreme.
- Denormals, 0.5 and signed zeros separate the underflow-to-zero path, which is inexact, from exact zeros.

On top of these, bad values are placed in lanes that are masked off, inactive or replaced by a broadcast lane. This shows that flags and results come only from written lanes.

Random operands and random output back-pressure run through a queue-based scoreboard. The scoreboard computes expected values with real-number truncation.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int DBL_W   = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int EXP_BIAS = 1023;
  localparam logic [DBL_W-1:0] INT_INDEF = {1'b1, {(DBL_W-1){1'b0}}};

  typedef enum logic [1:0] {
    LEN_128  = 2'd0,
    LEN_256  = 2'd1,
    LEN_512  = 2'd2,
    LEN_512X = 2'd3
  } vlen_e;
endpackage

// File: rtl/cvt_lane.sv
module cvt_lane
  import cvt_pkg::*;
(
  input  logic [DBL_W-1:0] val,
  output logic [DBL_W-1:0] res,
  output logic             inv,
  output logic             inx
);
  localparam int WIDE_W = DBL_W + FRAC_W;        // 116
  localparam int SH_W   = $clog2(DBL_W);         // 6
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(EXP_BIAS);
  localparam logic [EXP_W-1:0] EXP_OVF  = EXP_W'(EXP_BIAS + DBL_W - 1);
  localparam logic [EXP_W-1:0] EXP_SPEC = {EXP_W{1'b1}};

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;
  logic [DBL_W-1:0]  mag;

  always_comb begin
    sgn  = val[DBL_W-1];
    ex   = val[DBL_W-2 -: EXP_W];
    fr   = val[FRAC_W-1:0];
    sh   = SH_W'(ex - EXP_ONE);
    wide = {{(WIDE_W-FRAC_W-1){1'b0}}, 1'b1, fr} << sh;
    mag  = wide[WIDE_W-1:FRAC_W];
    res  = '0;
    inv  = 1'b0;
    inx  = 1'b0;
    if (ex == EXP_SPEC) begin
      res = INT_INDEF;
      inv = 1'b1;
    end else if (ex < EXP_ONE) begin
      inx = (ex != '0) || (fr != '0);
    end else if (ex >= EXP_OVF) begin
      res = INT_INDEF;
      inv = !(sgn && (ex == EXP_OVF) && (fr == '0));
    end else begin
      res = sgn ? -mag : mag;
      inx = |wide[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/cvt_lane_pick.sv
module cvt_lane_pick
  import cvt_pkg::*;
(
  input  logic             active,
  input  logic             write,
  input  logic             zero_mode,
  input  logic [DBL_W-1:0] conv,
  input  logic [DBL_W-1:0] old,
  input  logic             c_inv,
  input  logic             c_inx,
  output logic [DBL_W-1:0] data,
  output logic             inv,
  output logic             inx
);
  always_comb begin
    if (!active)        data = '0;
    else if (write)     data = conv;
    else if (zero_mode) data = '0;
    else                data = old;
    inv = active && write && c_inv;
    inx = active && write && c_inx;
  end
endmodule

// File: rtl/f64_to_i64_vec.sv
module f64_to_i64_vec
  import cvt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             in_vlen,
  input  logic                   in_mask_en,
  input  logic [LANES-1:0]       in_mask,
  input  logic                   in_zero_mode,
  input  logic                   in_bcast,
  input  logic [LANES*64-1:0]    in_src,
  input  logic [LANES*64-1:0]    in_old,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*64-1:0]    out_data,
  output logic                   out_invalid,
  output logic                   out_inexact
);
  localparam int DATA_W = LANES * DBL_W;
  localparam int LIM_W  = 5;

  logic [LIM_W-1:0]  lane_lim;
  logic [DATA_W-1:0] nxt_data;
  logic [LANES-1:0]  l_inv, l_inx;
  logic              take;

  assign lane_lim = LIM_W'(2) << in_vlen;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [DBL_W-1:0] src_j, conv_j;
    logic             cinv_j, cinx_j;

    assign src_j = in_bcast ? in_src[DBL_W-1:0] : in_src[j*DBL_W +: DBL_W];

    cvt_lane u_cvt (
      .val (src_j),
      .res (conv_j),
      .inv (cinv_j),
      .inx (cinx_j)
    );

    cvt_lane_pick u_pick (
      .active    (LIM_W'(j) < lane_lim),
      .write     (!in_mask_en || in_mask[j]),
      .zero_mode (in_zero_mode),
      .conv      (conv_j),
      .old       (in_old[j*DBL_W +: DBL_W]),
      .c_inv     (cinv_j),
      .c_inx     (cinx_j),
      .data      (nxt_data[j*DBL_W +: DBL_W]),
      .inv       (l_inv[j]),
      .inx       (l_inx[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_data    <= nxt_data;
        out_invalid <= |l_inv;
        out_inexact <= |l_inx;
      end
    end
  end
endmodule

// File: rtl/f64_to_i64_vec_chk.sv
module f64_to_i64_vec_chk
  import cvt_pkg::*;
#(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [1:0]          in_vlen,
  input logic                in_mask_en,
  input logic [LANES-1:0]    in_mask,
  input logic                in_zero_mode,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*64-1:0] out_data,
  input logic                out_invalid
);
  logic [LANES-1:0]          zlanes, zlanes_q;
  logic [LANES*DBL_W-1:0]    zbits;
  logic                      has_indef;

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      zlanes[j] = (5'(j) >= (5'd2 << in_vlen)) ||
                  (in_mask_en && in_zero_mode && !in_mask[j]);
      zbits[j*DBL_W +: DBL_W] = {DBL_W{zlanes_q[j]}};
    end
    has_indef = 1'b0;
    for (int j = 0; j < LANES; j++)
      if (out_data[j*DBL_W +: DBL_W] == INT_INDEF) has_indef = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) zlanes_q <= '0;
    else if (in_valid && in_ready) zlanes_q <= zlanes;
  end

  assert_hold_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_accept_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R3 and R5: lanes beyond the length and zero-masked lanes read zero
  assert_zero_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & zbits) == '0));

  assert_invalid_indef_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> has_indef);
endmodule

bind f64_to_i64_vec f64_to_i64_vec_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_vlen(in_vlen), .in_mask_en(in_mask_en), .in_mask(in_mask),
  .in_zero_mode(in_zero_mode), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_invalid(out_invalid)
);

// File: tb/f64_to_i64_vec_bench.sv
module f64_to_i64_vec_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_vlen = 2'd2;
  logic         in_mask_en = 1'b0;
  logic [7:0]   in_mask = '0;
  logic         in_zero_mode = 1'b0;
  logic         in_bcast = 1'b0;
  logic [511:0] in_src = '0;
  logic [511:0] in_old = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [511:0] out_data;
  logic         out_invalid, out_inexact;

  int n_tests = 0;
  int n_fail  = 0;

  logic [513:0] exp_q[$];
  string        tag_q[$];

  localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  f64_to_i64_vec u_f64_to_i64_vec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vlen(in_vlen), .in_mask_en(in_mask_en), .in_mask(in_mask),
    .in_zero_mode(in_zero_mode), .in_bcast(in_bcast), .in_src(in_src),
    .in_old(in_old), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic ref_lane(input logic [63:0] v, output logic [63:0] r,
                          output bit inv, output bit inx);
    real x, t, lim;
    lim = 2.0 ** 63;
    inv = 0; inx = 0; r = '0;
    if (v[62:52] == 11'h7ff) begin
      r = INDEF; inv = 1;
    end else begin
      x = $bitstoreal(v);
      if (x >= lim || x < -lim) begin
        r = INDEF; inv = 1;
      end else begin
        t = (x >= 0.0) ? $floor(x) : $ceil(x);
        r = 64'(longint'(t));
        inx = (t != x);
      end
    end
  endtask

  task automatic send(input string tag, input logic [1:0] vlen, input bit men,
                      input logic [7:0] msk, input bit zm, input bit bc,
                      input logic [511:0] src, input logic [511:0] old);
    logic [511:0] ed;
    bit einv, einx;
    int nl;
    ed = '0; einv = 0; einx = 0;
    nl = (vlen == 2'd0) ? 2 : (vlen == 2'd1) ? 4 : 8;
    for (int j = 0; j < 8; j++) begin
      logic [63:0] s, r;
      bit li, lx;
      if (j < nl) begin
        if (!men || msk[j]) begin
          s = bc ? src[63:0] : src[j*64 +: 64];
          ref_lane(s, r, li, lx);
          ed[j*64 +: 64] = r;
          einv |= li; einx |= lx;
        end else if (!zm) begin
          ed[j*64 +: 64] = old[j*64 +: 64];
        end
      end
    end
    @(negedge clk);
    in_vlen = vlen; in_mask_en = men; in_mask = msk; in_zero_mode = zm;
    in_bcast = bc; in_src = src; in_old = old; in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    exp_q.push_back({einv, einx, ed});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] rnd_dbl();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if (($urandom % 8) != 0) v[62:52] = 11'(1000 + ($urandom % 90));
    return v;
  endfunction

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      out_ready <= (($urandom % 4) != 0);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1", "unexpected result", out_data, '0);
        end else begin
          logic [513:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e[511:0], t, "data", out_data, e[511:0]);
          chk(out_invalid == e[513], t, "invalid", 512'(out_invalid), 512'(e[513]));
          chk(out_inexact == e[512], t, "inexact", 512'(out_inexact), 512'(e[512]));
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    chk(0, "R1", "watchdog expired", '0, '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [511:0] old_pat;

  initial begin
    old_pat = {8{64'hA5A5_0000_5A5A_FFFF}};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #3;
    chk(out_valid == 1'b0, "R1", "reset out_valid", 512'(out_valid), '0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", 512'(in_ready), 512'(1));

    // R2 truncation of mixed values, 512-bit
    send("R2", 2'd2, 0, 8'h00, 0, 0,
         {64'hC1D0_0000_0000_8000, 64'h3FE0_0000_0000_0000, 64'h4330_0000_0000_0000,
          64'h43DF_FFFF_FFFF_FFFF, 64'hBFF0_0000_0000_0000, 64'h4008_0000_0000_0000,
          64'hC006_0000_0000_0000, 64'h3FF8_0000_0000_0000}, old_pat);
    // R7 invalid inputs and -2^63 boundary
    send("R7", 2'd3, 0, 8'h00, 0, 0,
         {64'h4000_0000_0000_0000, 64'hC3E0_0000_0000_0000, 64'h43E0_0000_0000_0000,
          64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'h7FF8_0000_0000_0001,
          64'hC3E0_0000_0000_0001, 64'h4000_0000_0000_0000}, old_pat);
    send("R7", 2'd2, 0, 8'h00, 0, 0,
         {7{64'h4010_0000_0000_0000}} << 64 | 512'h0000_0000_0000_0000_C3E0_0000_0000_0000,
         old_pat);
    // R8 denormal, signed zeros, exact values
    send("R8", 2'd2, 0, 8'h00, 0, 0,
         {64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000,
          64'h4024_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
          64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000}, old_pat);
    send("R8", 2'd2, 0, 8'h00, 0, 0,
         {{7{64'h0000_0000_0000_0000}}, 64'h0000_0000_0000_0001}, old_pat);
    // R3 vector length 128 and 256 with old data present
    send("R3", 2'd0, 0, 8'h00, 0, 0, {8{64'h4059_0000_0000_0000}}, old_pat);
    send("R3", 2'd1, 1, 8'h05, 0, 0, {8{64'hC059_0000_0000_0000}}, old_pat);
    // R4 / R5 merging with mask
    send("R4", 2'd2, 1, 8'hA5, 0, 0, {8{64'h3FF8_0000_0000_0000}}, old_pat);
    // R5 zeroing with mask
    send("R5", 2'd2, 1, 8'h5A, 1, 0, {8{64'hC006_0000_0000_0000}}, old_pat);
    // R9 bad values only in masked-off and inactive lanes
    send("R9", 2'd2, 1, 8'h0F, 0, 0,
         {{4{64'h7FF8_0000_0000_0000}}, {4{64'h4008_0000_0000_0000}}}, old_pat);
    send("R9", 2'd0, 0, 8'h00, 0, 0,
         {{6{64'h3FF8_0000_0000_0000}}, {2{64'h4008_0000_0000_0000}}}, old_pat);
    // R6 broadcast of lane 0 over invalid lanes
    send("R6", 2'd2, 0, 8'h00, 0, 1,
         {{7{64'h7FF0_0000_0000_0000}}, 64'hC006_0000_0000_0000}, old_pat);
    send("R6", 2'd1, 1, 8'h09, 1, 1,
         {{7{64'h7FF8_0000_0000_0000}}, 64'h4330_0000_0000_0007}, old_pat);

    for (int k = 0; k < 300; k++) begin
      logic [511:0] s, o;
      for (int j = 0; j < 8; j++) begin
        s[j*64 +: 64] = rnd_dbl();
        o[j*64 +: 64] = {$urandom, $urandom};
      end
      send("R2", 2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
           (($urandom % 6) == 0), s, o);
    end

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "results outstanding", 512'(exp_q.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule